// File: doc/BRIEF.md
# I2C Target with Bus Error Detection

This block is a 7-bit-address I2C target that sits behind a small register-side port. It watches the bus through synchronized copies of SCL and SDA. It answers an address that matches a configurable own address. Received bytes go into a one-byte receive register, and bytes to be sent are taken from a one-byte transmit register. The block pulls SDA low to acknowledge or to send a zero. When clock stretching is enabled, it also holds SCL low until the local side has serviced the data register.

Four failure cases are caught and latched in sticky status flags. The first is a start or stop condition that arrives in the middle of a byte. The second is a NACK from the controller while the target is sending. The other two occur only when stretching is off: a byte that arrives while the previous one is still unread, and a byte that must be sent before a new one was written. Each flag is cleared by its own strobe. A single error interrupt is raised from the flags when it is enabled.

Top module: `i2c_tgt_errdet`

## Requirements
- R1: After reset, scl_oe and sda_oe are 0, rx_full is 0, tx_empty is 1, err_flags is 0 and err_irq is 0.
- R2: The first byte after a start is an address byte, sent most significant bit first. The block pulls SDA low in the ninth clock only when bits 7..1 of that byte equal own_addr. On a mismatch it does not acknowledge, and it ignores the bus until the next start. Bit 0 of the address byte selects the direction: 0 means the controller writes, 1 means the controller reads.
- R3: In a write, each data byte is shifted in most significant bit first and acknowledged. It then appears on rx_data with rx_full at 1. A one-cycle rd_stb pulse clears rx_full.
- R4: In a read, the byte last loaded by a wr_stb pulse (which drives tx_empty to 0) is sent most significant bit first. tx_empty returns to 1 once the byte has been taken for sending.
- R5: With stretch_en at 1 in a write, the block holds SCL low after an acknowledge while rx_full is 1. It releases SCL once rd_stb has cleared rx_full, so no overrun occurs.
- R6: With stretch_en at 1 in a read, the block holds SCL low when a byte must be sent while tx_empty is 1. It releases SCL once wr_stb has supplied a byte, so no underrun occurs.
- R7: With stretch_en at 0, a data byte that completes while rx_full is 1 is lost (rx_data keeps the unread byte) and sets err_flags bit 2 (overrun).
- R8: With stretch_en at 0, a byte that must be sent while tx_empty is 1 causes the transmit register to be sent again, and sets err_flags bit 3 (underrun).
- R9: A NACK from the controller after a byte sent by the block sets err_flags bit 1 (acknowledge failure). The block then releases SDA and SCL and drives nothing until the next start.
- R10: A start condition seen after at least two bits of a byte have been clocked sets err_flags bit 0 (bus error). The partial byte is discarded and the next byte is handled as a fresh address byte.
- R11: A stop condition seen after at least two bits of a byte have been clocked sets err_flags bit 0. The partial byte is discarded, both lines are released, and further bytes are ignored until a start.
- R12: The flags are sticky. Bit i of err_clr clears flag i, using the same bit positions as err_flags. A set and a clear in the same cycle leave the flag set. err_irq is 1 exactly when err_irq_en is 1 and at least one flag is set.
- R13: SCL and SDA pass through two synchronizing flops. A change on a pin is acted on at the third rising clk edge after it appears there. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretching) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | AW | Own 7-bit address |
| stretch_en | input | 1 | Enables clock stretching |
| rd_stb | input | 1 | Read strobe for the receive register |
| rx_data | output | DW | Receive register |
| rx_full | output | 1 | Receive register holds an unread byte |
| wr_stb | input | 1 | Write strobe for the transmit register |
| wr_data | input | DW | Byte written with wr_stb |
| tx_empty | output | 1 | Transmit register has no fresh byte |
| err_irq_en | input | 1 | Error interrupt enable |
| err_clr | input | ERR_N | Per-flag clear strobes |
| err_flags | output | ERR_N | Sticky flags: 0 bus error, 1 ack failure, 2 overrun, 3 underrun |
| err_irq | output | 1 | Error interrupt |

## Verification
A flag can be set by the bus in the same cycle that the local side strobes its clear. The bench provokes this with a NACK: it raises SCL for the acknowledge bit and, counting the synchronizer latency of R13, places the acknowledge-failure clear strobe exactly on the third edge. The flag must still read 1 afterwards, and a later lone clear must bring it to 0. A receive-register read can also coincide with the completion of the next byte; in that case the read is honoured and the new byte is kept, not reported as an overrun.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int ERR_N   = 4;
   localparam int ERR_BUS = 0;
   localparam int ERR_ACK = 1;
   localparam int ERR_OVR = 2;
   localparam int ERR_UDR = 3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RXB,
      ST_ACK,
      ST_STRETCH,
      ST_TXSET,
      ST_TX,
      ST_MACK
   } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_pin,
   input  logic sda_pin,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
         sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_buf.sv
module i2c_tgt_buf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_load,
   input  logic [DW-1:0] rx_in,
   input  logic          rd_stb,
   output logic [DW-1:0] rx_q,
   output logic          rx_full,
   input  logic          wr_stb,
   input  logic [DW-1:0] wr_data,
   input  logic          tx_take,
   output logic [DW-1:0] tx_q,
   output logic          tx_empty
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rx_full <= 1'b0;
      end else if (rx_load) begin
         rx_q    <= rx_in;
         rx_full <= 1'b1;
      end else if (rd_stb) begin
         rx_full <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q     <= '0;
         tx_empty <= 1'b1;
      end else if (wr_stb) begin
         tx_q     <= wr_data;
         tx_empty <= 1'b0;
      end else if (tx_take) begin
         tx_empty <= 1'b1;
      end
   end

   a_r3_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load |=> rx_full);

   a_r4_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_take && !wr_stb) |=> tx_empty);

endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         irq_en,
   output logic [N-1:0] flags,
   output logic         irq
);

   generate
      if (N < 1) begin : g_bad_n
         $error("i2c_tgt_flags: N must be at least 1");
      end
      for (genvar i = 0; i < N; i++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= 1'b0;
            else if (set[i]) q <= 1'b1;
            else if (clr[i]) q <= 1'b0;
         end
         assign flags[i] = q;

         a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
      end
   endgenerate

   assign irq = irq_en & (|flags);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine import i2c_tgt_pkg::*; #(
   parameter int DW = 8,
   parameter int AW = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             sda_s,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [AW-1:0]    own_addr,
   input  logic             stretch_en,
   input  logic             rx_full,
   input  logic             rd_stb,
   input  logic             tx_empty,
   input  logic [DW-1:0]    tx_q,
   output logic             rx_load,
   output logic [DW-1:0]    rx_byte,
   output logic             tx_take,
   output logic [ERR_N-1:0] err_set,
   output logic             sda_oe,
   output logic             scl_oe
);

   localparam int             CW       = $clog2(DW + 1);
   localparam logic [CW-1:0]  CNT_FULL = CW'(DW);
   localparam logic [CW-1:0]  CNT_MID  = CW'(2);

   generate
      if (DW != AW + 1) begin : g_bad_width
         $error("i2c_tgt_engine: DW must equal AW + 1");
      end
   endgenerate

   tgt_state_t    st, st_n;
   logic [CW-1:0] cnt, cnt_n;
   logic [DW-1:0] sr, sr_n;
   logic          is_addr, is_addr_n;
   logic          rd_dir, rd_dir_n;
   logic          advance, load, mid_byte;
   logic          sda_oe_n, scl_oe_n;

   assign mid_byte = ((st == ST_RXB) || (st == ST_TX)) && (cnt >= CNT_MID);

   always_comb begin
      st_n      = st;
      cnt_n     = cnt;
      sr_n      = sr;
      is_addr_n = is_addr;
      rd_dir_n  = rd_dir;
      err_set   = '0;
      rx_load   = 1'b0;
      tx_take   = 1'b0;
      advance   = 1'b0;
      load      = 1'b0;

      case (st)
         ST_RXB: begin
            if (scl_rise) begin
               sr_n  = {sr[DW-2:0], sda_s};
               cnt_n = cnt + 1'b1;
            end else if (scl_fall && (cnt == CNT_FULL)) begin
               if (is_addr) begin
                  if (sr[DW-1:1] == own_addr) begin
                     rd_dir_n = sr[0];
                     st_n     = ST_ACK;
                  end else begin
                     st_n = ST_IDLE;
                  end
               end else begin
                  if (rx_full && !rd_stb) err_set[ERR_OVR] = 1'b1;
                  else                    rx_load          = 1'b1;
                  st_n = ST_ACK;
               end
            end
         end
         ST_ACK: begin
            if (scl_fall) advance = 1'b1;
         end
         ST_MACK: begin
            if (scl_rise && sda_s) begin
               err_set[ERR_ACK] = 1'b1;
               st_n             = ST_IDLE;
            end else if (scl_fall) begin
               advance = 1'b1;
            end
         end
         ST_STRETCH: begin
            if (rd_dir) begin
               if (!tx_empty || !stretch_en) load = 1'b1;
            end else if (!rx_full || !stretch_en) begin
               st_n      = ST_RXB;
               cnt_n     = '0;
               is_addr_n = 1'b0;
            end
         end
         ST_TXSET: begin
            st_n = ST_TX;
         end
         ST_TX: begin
            if (scl_rise) begin
               cnt_n = cnt + 1'b1;
            end else if (scl_fall) begin
               if (cnt == CNT_FULL) st_n = ST_MACK;
               else                 sr_n = {sr[DW-2:0], 1'b0};
            end
         end
         default: ;
      endcase

      if (advance) begin
         if (rd_dir) begin
            if (tx_empty && stretch_en) st_n = ST_STRETCH;
            else                        load = 1'b1;
         end else if (rx_full && !rd_stb && stretch_en) begin
            st_n = ST_STRETCH;
         end else begin
            st_n      = ST_RXB;
            cnt_n     = '0;
            is_addr_n = 1'b0;
         end
      end

      if (load) begin
         tx_take = 1'b1;
         if (tx_empty) err_set[ERR_UDR] = 1'b1;
         sr_n  = tx_q;
         cnt_n = '0;
         st_n  = ST_TXSET;
      end

      if (start_det || stop_det) begin
         err_set          = '0;
         err_set[ERR_BUS] = mid_byte;
         rx_load          = 1'b0;
         tx_take          = 1'b0;
         cnt_n            = '0;
         sr_n             = sr;
         if (start_det) begin
            st_n      = ST_RXB;
            is_addr_n = 1'b1;
         end else begin
            st_n = ST_IDLE;
         end
      end
   end

   assign sda_oe_n = (st_n == ST_ACK) ||
                     (((st_n == ST_TX) || (st_n == ST_TXSET)) && !sr_n[DW-1]);
   assign scl_oe_n = (st_n == ST_STRETCH) || (st_n == ST_TXSET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         sr      <= '0;
         is_addr <= 1'b0;
         rd_dir  <= 1'b0;
         sda_oe  <= 1'b0;
         scl_oe  <= 1'b0;
      end else begin
         st      <= st_n;
         cnt     <= cnt_n;
         sr      <= sr_n;
         is_addr <= is_addr_n;
         rd_dir  <= rd_dir_n;
         sda_oe  <= sda_oe_n;
         scl_oe  <= scl_oe_n;
      end
   end

   assign rx_byte = sr;

   a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
      err_set[ERR_ACK] |=> (!sda_oe && !scl_oe));

   a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && !scl_oe));

   a_r7_ovr_only_unstretched: assert property (@(posedge clk) disable iff (!rst_n)
      err_set[ERR_OVR] |-> !stretch_en);

   a_r8_udr_only_unstretched: assert property (@(posedge clk) disable iff (!rst_n)
      err_set[ERR_UDR] |-> !stretch_en);

endmodule

// File: rtl/i2c_tgt_errdet.sv
module i2c_tgt_errdet import i2c_tgt_pkg::*; #(
   parameter int DW          = 8,
   parameter int AW          = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             scl_oe,
   output logic             sda_oe,
   input  logic [AW-1:0]    own_addr,
   input  logic             stretch_en,
   input  logic             rd_stb,
   output logic [DW-1:0]    rx_data,
   output logic             rx_full,
   input  logic             wr_stb,
   input  logic [DW-1:0]    wr_data,
   output logic             tx_empty,
   input  logic             err_irq_en,
   input  logic [ERR_N-1:0] err_clr,
   output logic [ERR_N-1:0] err_flags,
   output logic             err_irq
);

   logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic             rx_load, tx_take;
   logic [DW-1:0]    rx_byte, tx_q;
   logic [ERR_N-1:0] err_set;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_pin   (scl_i),
      .sda_pin   (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_tgt_engine #(.DW(DW), .AW(AW)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .sda_s      (sda_s),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .own_addr   (own_addr),
      .stretch_en (stretch_en),
      .rx_full    (rx_full),
      .rd_stb     (rd_stb),
      .tx_empty   (tx_empty),
      .tx_q       (tx_q),
      .rx_load    (rx_load),
      .rx_byte    (rx_byte),
      .tx_take    (tx_take),
      .err_set    (err_set),
      .sda_oe     (sda_oe),
      .scl_oe     (scl_oe)
   );

   i2c_tgt_buf #(.DW(DW)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_load  (rx_load),
      .rx_in    (rx_byte),
      .rd_stb   (rd_stb),
      .rx_q     (rx_data),
      .rx_full  (rx_full),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data),
      .tx_take  (tx_take),
      .tx_q     (tx_q),
      .tx_empty (tx_empty)
   );

   i2c_tgt_flags #(.N(ERR_N)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (err_set),
      .clr    (err_clr),
      .irq_en (err_irq_en),
      .flags  (err_flags),
      .irq    (err_irq)
   );

   a_r12_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !err_irq_en |-> !err_irq);

endmodule

// File: tb/i2c_tgt_errdet_tb_top.sv
`timescale 1ns/1ps
module i2c_tgt_errdet_tb_top;

   localparam int Q = 8;
   localparam logic [6:0] MY_ADDR = 7'h3A;
   localparam logic [7:0] AW_BYTE = {MY_ADDR, 1'b0};
   localparam logic [7:0] AR_BYTE = {MY_ADDR, 1'b1};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1, sda_m = 1'b1;
   logic       scl_line, sda_line;
   logic       scl_oe, sda_oe;
   logic       stretch_en = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, err_irq_en = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rx_data;
   logic       rx_full, tx_empty, err_irq;
   logic [3:0] err_clr = 4'h0, err_flags;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   assign scl_line = scl_m & ~scl_oe;
   assign sda_line = sda_m & ~sda_oe;

   i2c_tgt_errdet dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(MY_ADDR),
      .stretch_en(stretch_en), .rd_stb(rd_stb), .rx_data(rx_data),
      .rx_full(rx_full), .wr_stb(wr_stb), .wr_data(wr_data),
      .tx_empty(tx_empty), .err_irq_en(err_irq_en), .err_clr(err_clr),
      .err_flags(err_flags), .err_irq(err_irq));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic wait_high();
      while (!scl_line) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; qwait(); scl_m = 1'b1; wait_high(); qwait();
      sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; qwait(); scl_m = 1'b1; wait_high(); qwait();
      sda_m = 1'b1; qwait();
   endtask

   task automatic m_wbit(input logic b);
      sda_m = b; qwait(); scl_m = 1'b1; wait_high(); qwait(); qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_rbit(output logic b);
      sda_m = 1'b1; qwait(); scl_m = 1'b1; wait_high(); qwait();
      b = sda_line; qwait(); scl_m = 1'b0; qwait();
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) m_wbit(d[i]);
      m_rbit(b);
      ack = ~b;
   endtask

   task automatic m_rbyte(output logic [7:0] d, input logic nack);
      for (int i = 7; i >= 0; i--) m_rbit(d[i]);
      m_wbit(nack);
   endtask

   task automatic pulse_rd();
      @(negedge clk) rd_stb = 1'b1;
      @(negedge clk) rd_stb = 1'b0;
   endtask

   task automatic load_tx(input logic [7:0] d);
      @(negedge clk) begin wr_stb = 1'b1; wr_data = d; end
      @(negedge clk) wr_stb = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk) err_clr = 4'hF;
      @(negedge clk) err_clr = 4'h0;
   endtask

   task automatic t_reset();
      chk("R1 scl_oe", scl_oe, 0);
      chk("R1 sda_oe", sda_oe, 0);
      chk("R1 rx_full", rx_full, 0);
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 flags", err_flags, 0);
      chk("R1 irq", err_irq, 0);
   endtask

   task automatic t_mismatch();
      logic ack;
      m_start();
      m_wbyte({MY_ADDR ^ 7'h01, 1'b0}, ack);
      chk("R2 no ack on mismatch", ack, 0);
      m_stop();
      chk("R2 nothing received", rx_full, 0);
   endtask

   task automatic t_write();
      logic ack;
      m_start();
      m_wbyte(AW_BYTE, ack);
      chk("R2 ack on match", ack, 1);
      m_wbyte(8'hA5, ack);
      chk("R3 data ack", ack, 1);
      chk("R3 rx_data", rx_data, 8'hA5);
      chk("R3 rx_full", rx_full, 1);
      pulse_rd();
      chk("R3 rd clears full", rx_full, 0);
      m_wbyte(8'h3C, ack);
      chk("R3 second byte", rx_data, 8'h3C);
      pulse_rd();
      m_stop();
      chk("R3 no flags", err_flags, 0);
   endtask

   task automatic t_overrun();
      logic ack;
      m_start();
      m_wbyte(AW_BYTE, ack);
      m_wbyte(8'h11, ack);
      m_wbyte(8'h22, ack);
      m_stop();
      chk("R7 byte lost", rx_data, 8'h11);
      chk("R7 overrun flag", err_flags, 4'b0100);
      chk("R12 irq on", err_irq, 1);
      @(negedge clk) err_irq_en = 1'b0;
      @(negedge clk);
      chk("R12 irq gated", err_irq, 0);
      err_irq_en = 1'b1;
      @(negedge clk);
      chk("R12 flag sticky", err_flags, 4'b0100);
      @(negedge clk) err_clr = 4'b0100;
      @(negedge clk) err_clr = 4'b0000;
      chk("R12 clear", err_flags, 0);
      chk("R12 irq cleared", err_irq, 0);
      pulse_rd();
   endtask

   task automatic t_stretch_rx();
      logic ack;
      stretch_en = 1'b1;
      m_start();
      m_wbyte(AW_BYTE, ack);
      m_wbyte(8'h55, ack);
      fork
         m_wbyte(8'h66, ack);
         begin
            repeat (40) @(negedge clk);
            chk("R5 scl held", scl_line, 0);
            chk("R5 old byte", rx_data, 8'h55);
            pulse_rd();
         end
      join
      chk("R5 new byte", rx_data, 8'h66);
      chk("R5 no overrun", err_flags, 0);
      pulse_rd();
      m_stop();
      stretch_en = 1'b0;
   endtask

   task automatic t_read_nack();
      logic ack;
      logic [7:0] d;
      load_tx(8'hC3);
      chk("R4 tx_empty after write", tx_empty, 0);
      m_start();
      m_wbyte(AR_BYTE, ack);
      chk("R2 read addr ack", ack, 1);
      m_rbyte(d, 1'b1);
      chk("R4 read data", d, 8'hC3);
      chk("R4 tx_empty after send", tx_empty, 1);
      chk("R9 ack failure flag", err_flags, 4'b0010);
      chk("R9 sda released", sda_oe, 0);
      m_rbit(ack);
      chk("R9 no drive after nack", ack, 1);
      m_stop();
      clear_all();
   endtask

   task automatic t_underrun();
      logic ack;
      logic [7:0] d;
      load_tx(8'h96);
      m_start();
      m_wbyte(AR_BYTE, ack);
      m_rbyte(d, 1'b0);
      chk("R4 first byte", d, 8'h96);
      m_rbyte(d, 1'b1);
      chk("R8 resent byte", d, 8'h96);
      chk("R8 underrun flag", err_flags, 4'b1010);
      m_stop();
      clear_all();
   endtask

   task automatic t_stretch_tx();
      logic ack;
      logic [7:0] d;
      stretch_en = 1'b1;
      m_start();
      m_wbyte(AR_BYTE, ack);
      fork
         m_rbyte(d, 1'b1);
         begin
            repeat (40) @(negedge clk);
            chk("R6 scl held", scl_line, 0);
            load_tx(8'h7E);
         end
      join
      chk("R6 byte sent", d, 8'h7E);
      chk("R6 no underrun", err_flags, 4'b0010);
      m_stop();
      stretch_en = 1'b0;
      clear_all();
   endtask

   task automatic t_bad_start();
      logic ack;
      m_start();
      m_wbyte(AW_BYTE, ack);
      m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1);
      m_start();
      chk("R10 bus error", err_flags, 4'b0001);
      chk("R10 partial discarded", rx_full, 0);
      m_wbyte(AW_BYTE, ack);
      chk("R10 address after restart", ack, 1);
      m_wbyte(8'h42, ack);
      chk("R10 data after restart", rx_data, 8'h42);
      pulse_rd();
      m_stop();
      clear_all();
   endtask

   task automatic t_bad_stop();
      logic ack;
      m_start();
      m_wbyte(AW_BYTE, ack);
      m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1); m_wbit(1'b0);
      m_stop();
      chk("R11 bus error", err_flags, 4'b0001);
      chk("R11 sda released", sda_oe, 0);
      chk("R11 scl released", scl_oe, 0);
      chk("R11 partial discarded", rx_full, 0);
      m_wbyte(8'h5D, ack);
      chk("R11 ignored until start", ack, 0);
      chk("R11 no byte stored", rx_full, 0);
      clear_all();
   endtask

   task automatic t_set_clear();
      logic ack;
      logic [7:0] d;
      load_tx(8'hA0);
      m_start();
      m_wbyte(AR_BYTE, ack);
      for (int i = 7; i >= 0; i--) m_rbit(d[i]);
      chk("R4 data before nack", d, 8'hA0);
      sda_m = 1'b1; qwait(); scl_m = 1'b1;
      @(negedge clk); @(negedge clk);
      err_clr = 4'b0010;
      @(negedge clk);
      err_clr = 4'b0000;
      chk("R12 set beats clear (R13 latency)", err_flags[1], 1);
      qwait(); scl_m = 1'b0; qwait();
      @(negedge clk) err_clr = 4'b0010;
      @(negedge clk) err_clr = 4'b0000;
      chk("R12 lone clear", err_flags[1], 0);
      m_stop();
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mismatch();
      t_write();
      t_overrun();
      t_stretch_rx();
      t_read_nack();
      t_underrun();
      t_stretch_tx();
      t_bad_start();
      t_bad_stop();
      t_set_clear();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R13 watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule